// File: doc/BRIEF.md
# ADC Conversion Scheduler with Tailgating

This block sits between the control logic of an analog-to-digital converter and the successive-approximation core that does the actual conversion. It serves two request sources. The single channel converts one chosen input. The scan channel walks through every input enabled in a bit mask, from the lowest-numbered input upward. Each source keeps its own result register, data-valid flag and sticky overflow flag. Each source can convert once per trigger, or re-arm itself and run continuously.

The scheduler decides which source uses the core next. For every conversion it drives a one-cycle start pulse, a channel index and a differential-select bit. When the core answers with a done pulse and a 12-bit value, the scheduler stores that value in the result register of the source that asked for it. Scan normally wins over single, but a single request is slotted between two samples of a sweep that is already under way. An optional tailgate setting holds every single request until the next scan sweep has finished, which keeps the sweep period free of jitter.

A result can be read in two ways. A read strobe clears the data-valid flag. Looking at the data outputs without the strobe is a peek, and it leaves the flag as it was.

Top module: `adc_conv_sched`

## Requirements
- R1: Single and scan keep separate result registers, valid flags and overflow flags. After reset no conversion runs and every flag and result reads zero.
- R2: When both sources are pending and the current sweep has issued no sample yet, the scan sample is issued first.
- R3: `core_start` is a one-cycle pulse. No new start is issued until `core_done` has answered the previous one, so a scan trigger never cuts short a running single conversion. The earliest start comes on the second rising edge after a trigger.
- R4: A single request that becomes pending while a sweep is under way is issued right after the current scan sample completes, before the next scan sample.
- R5: A scan sweep converts each input whose bit is set in `scan_mask` exactly once, in ascending index order. `scan_chan` reports the input that produced `scan_data`. A trigger with an all-zero mask issues nothing and sets no flag.
- R6: With `tailgate_en` high, a pending single request waits until the end of the next scan sweep to finish, and it is issued directly after that sweep.
- R7: A valid flag goes high in the cycle after `core_done` stores a result for its source. It goes low in the cycle after a read strobe with no write. A write and a read in the same cycle leave it high.
- R8: The data outputs can be observed at any time (peek) without changing the valid flag.
- R9: The differential bit of the issuing source (`single_diff` or `scan_diff`) goes to `core_diff` together with the channel. Both stay stable until the matching `core_done`.
- R10: A trigger that arrives while the same source already has a pending or active request is merged into it and causes no extra conversion.
- R11: Storing a result while that source's valid flag is set and not being read sets that source's overflow flag. The flag then stays set until reset.
- R12: With the repeat bit set, a source re-arms after each conversion (single) or each sweep (scan). Clearing the bit lets the current request finish, and the source then stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tailgate_en | input | 1 | Hold single requests until a scan sweep ends |
| single_trig | input | 1 | Single-source trigger pulse |
| single_chan | input | CW | Input index for single conversions |
| single_diff | input | 1 | Differential select for single conversions |
| single_repeat | input | 1 | Single source re-arms after each conversion |
| single_rd | input | 1 | Read strobe, clears the single valid flag |
| single_data | output | RES_W | Single result register |
| single_valid | output | 1 | Single result not yet read |
| single_ovf | output | 1 | Sticky single overflow |
| scan_trig | input | 1 | Scan-source trigger pulse |
| scan_mask | input | N_INPUTS | Inputs included in a sweep |
| scan_diff | input | 1 | Differential select for scan conversions |
| scan_repeat | input | 1 | Scan source re-arms after each sweep |
| scan_rd | input | 1 | Read strobe, clears the scan valid flag |
| scan_data | output | RES_W | Scan result register |
| scan_chan | output | CW | Input index of the scan result |
| scan_valid | output | 1 | Scan result not yet read |
| scan_ovf | output | 1 | Sticky scan overflow |
| core_start | output | 1 | One-cycle conversion start to the core |
| core_chan | output | CW | Channel index for the core |
| core_diff | output | 1 | Differential select for the core |
| core_done | input | 1 | Conversion finished pulse from the core |
| core_result | input | RES_W | Conversion value, valid with core_done |

## Verification
A trigger sampled at rising edge k sets the request on that edge, and the earliest start pulse appears after edge k+1. A `core_done` sampled at edge d makes the result, the valid flag and any overflow visible after edge d, and a read strobe sampled at edge r drops the flag after edge r. The bench keeps a behavioural model that takes the same inputs on the same edge and advances by exactly these latencies. It compares every output against that model at each falling edge, so an output that is early or late by one cycle is reported. The bench also records the order of issued channels and checks it for the priority, interleave, preemption and tailgate cases.

// File: rtl/adc_sched_pkg.sv
package adc_sched_pkg;

   // Which source owns the conversion currently in the core
   typedef enum logic {
      SRC_SINGLE = 1'b0,
      SRC_SCAN   = 1'b1
   } conv_src_e;

endpackage

// File: rtl/adc_lowbit_pick.sv
// Finds the lowest set bit of a mask and returns the mask with that bit removed.
module adc_lowbit_pick #(
   parameter int N  = 8,
   parameter int CW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask,
   output logic [CW-1:0] idx,
   output logic          any,
   output logic [N-1:0]  rest
);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = CW'(i);
      end
   end

   assign any  = |mask;
   assign rest = mask & (mask - 1'b1);

endmodule

// File: rtl/adc_result_slot.sv
// One result register with data-valid and sticky overflow; optional tag.
module adc_result_slot #(
   parameter int DW      = 12,
   parameter int TW      = 3,
   parameter bit HAS_TAG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wr_data,
   input  logic [TW-1:0] wr_tag,
   input  logic          rd,
   output logic [DW-1:0] data,
   output logic [TW-1:0] tag,
   output logic          valid,
   output logic          ovf
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
         ovf   <= 1'b0;
      end else begin
         if (wr) begin
            data  <= wr_data;
            valid <= 1'b1;
            if (valid && !rd) ovf <= 1'b1;
         end else if (rd) begin
            valid <= 1'b0;
         end
      end
   end

   generate
      if (HAS_TAG) begin : g_tag
         logic [TW-1:0] tag_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  tag_q <= '0;
            else if (wr) tag_q <= wr_tag;
         end
         assign tag = tag_q;
      end else begin : g_no_tag
         logic unused_tag;
         assign unused_tag = ^wr_tag;
         assign tag        = '0;
      end
   endgenerate

endmodule

// File: rtl/adc_conv_sched.sv
module adc_conv_sched
   import adc_sched_pkg::*;
#(
   parameter int  N_INPUTS = 8,
   parameter int  RES_W    = 12,
   localparam int CW       = (N_INPUTS > 1) ? $clog2(N_INPUTS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tailgate_en,
   input  logic                single_trig,
   input  logic [CW-1:0]       single_chan,
   input  logic                single_diff,
   input  logic                single_repeat,
   input  logic                single_rd,
   output logic [RES_W-1:0]    single_data,
   output logic                single_valid,
   output logic                single_ovf,
   input  logic                scan_trig,
   input  logic [N_INPUTS-1:0] scan_mask,
   input  logic                scan_diff,
   input  logic                scan_repeat,
   input  logic                scan_rd,
   output logic [RES_W-1:0]    scan_data,
   output logic [CW-1:0]       scan_chan,
   output logic                scan_valid,
   output logic                scan_ovf,
   output logic                core_start,
   output logic [CW-1:0]       core_chan,
   output logic                core_diff,
   input  logic                core_done,
   input  logic [RES_W-1:0]    core_result
);

   // Elaboration-time parameter checks
   generate
      if (N_INPUTS < 2) begin : g_bad_inputs
         $error("adc_conv_sched: N_INPUTS must be at least 2");
      end
      if (RES_W < 1) begin : g_bad_width
         $error("adc_conv_sched: RES_W must be at least 1");
      end
   endgenerate

   // Core ownership
   logic          busy_q;
   conv_src_e     owner_q;
   logic          start_q;
   logic [CW-1:0] chan_q;
   logic          diff_q;

   // Single source state
   logic sreq_q;      // request pending or active
   logic srel_q;      // tailgate release granted by a finished sweep

   // Scan source state
   logic                sact_q;     // sweep in progress
   logic                sbegun_q;   // sweep has issued at least one sample
   logic [N_INPUTS-1:0] left_q;     // inputs not yet issued in this sweep

   // Next scan input
   logic [CW-1:0]       pick_idx;
   logic                pick_any;
   logic [N_INPUTS-1:0] pick_rest;

   adc_lowbit_pick #(.N(N_INPUTS), .CW(CW)) u_pick (
      .mask (left_q),
      .idx  (pick_idx),
      .any  (pick_any),
      .rest (pick_rest)
   );

   // Arbitration
   logic scan_ready, single_ready, grant_single, grant_scan, grant_any;
   logic conv_done, single_fin, scan_fin, sweep_end, sreq_n;

   always_comb begin
      scan_ready   = sact_q & pick_any;
      single_ready = sreq_q & (~tailgate_en | srel_q);
      grant_single = ~busy_q & single_ready & (~scan_ready | sbegun_q | tailgate_en);
      grant_scan   = ~busy_q & scan_ready & ~grant_single;
      grant_any    = grant_single | grant_scan;
      conv_done    = busy_q & core_done;
      single_fin   = conv_done & (owner_q == SRC_SINGLE);
      scan_fin     = conv_done & (owner_q == SRC_SCAN);
      sweep_end    = scan_fin & ~pick_any;
      if (sreq_q) sreq_n = ~(single_fin & ~single_repeat);
      else        sreq_n = single_trig;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         owner_q  <= SRC_SINGLE;
         start_q  <= 1'b0;
         chan_q   <= '0;
         diff_q   <= 1'b0;
         sreq_q   <= 1'b0;
         srel_q   <= 1'b0;
         sact_q   <= 1'b0;
         sbegun_q <= 1'b0;
         left_q   <= '0;
      end else begin
         start_q <= grant_any;
         if (grant_single) begin
            chan_q  <= single_chan;
            diff_q  <= single_diff;
            owner_q <= SRC_SINGLE;
         end else if (grant_scan) begin
            chan_q  <= pick_idx;
            diff_q  <= scan_diff;
            owner_q <= SRC_SCAN;
         end

         if (grant_any)      busy_q <= 1'b1;
         else if (conv_done) busy_q <= 1'b0;

         sreq_q <= sreq_n;
         if (grant_single)             srel_q <= 1'b0;
         else if (sweep_end && sreq_n) srel_q <= 1'b1;

         if (sweep_end) begin
            if (scan_repeat && |scan_mask) begin
               left_q   <= scan_mask;
               sbegun_q <= 1'b0;
            end else begin
               sact_q <= 1'b0;
            end
         end else if (!sact_q && scan_trig && |scan_mask) begin
            sact_q   <= 1'b1;
            left_q   <= scan_mask;
            sbegun_q <= 1'b0;
         end else if (grant_scan) begin
            left_q   <= pick_rest;
            sbegun_q <= 1'b1;
         end
      end
   end

   assign core_start = start_q;
   assign core_chan  = chan_q;
   assign core_diff  = diff_q;

   // Result registers
   logic [CW-1:0] unused_single_tag;

   adc_result_slot #(.DW(RES_W), .TW(CW), .HAS_TAG(1'b0)) u_single_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (single_fin),
      .wr_data (core_result),
      .wr_tag  (chan_q),
      .rd      (single_rd),
      .data    (single_data),
      .tag     (unused_single_tag),
      .valid   (single_valid),
      .ovf     (single_ovf)
   );

   adc_result_slot #(.DW(RES_W), .TW(CW), .HAS_TAG(1'b1)) u_scan_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (scan_fin),
      .wr_data (core_result),
      .wr_tag  (chan_q),
      .rd      (scan_rd),
      .data    (scan_data),
      .tag     (scan_chan),
      .valid   (scan_valid),
      .ovf     (scan_ovf)
   );

endmodule

// File: rtl/adc_conv_sched_chk.sv
module adc_conv_sched_chk #(
   parameter int CW = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          core_start,
   input logic          core_done,
   input logic [CW-1:0] core_chan,
   input logic          core_diff,
   input logic          single_rd,
   input logic          single_valid,
   input logic          single_ovf,
   input logic          scan_rd,
   input logic          scan_valid,
   input logic          scan_ovf
);

   // Outstanding conversion, tracked from the core handshake alone
   logic outst_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         outst_q <= 1'b0;
      else if (core_start) outst_q <= 1'b1;
      else if (core_done)  outst_q <= 1'b0;
   end

   assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |=> !core_start);

   assert_no_start_while_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      core_start |-> !outst_q);

   assert_chan_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (outst_q && !core_start) |-> ($stable(core_chan) && $stable(core_diff)));

   assert_valid_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (core_done && outst_q) |=> (single_valid || scan_valid));

   assert_single_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (single_rd && !core_done) |=> !single_valid);

   assert_scan_rd_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_rd && !core_done) |=> !scan_valid);

   assert_single_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      single_ovf |=> single_ovf);

   assert_scan_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      scan_ovf |=> scan_ovf);

endmodule

bind adc_conv_sched adc_conv_sched_chk #(.CW(CW)) u_sched_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .core_start   (core_start),
   .core_done    (core_done),
   .core_chan    (core_chan),
   .core_diff    (core_diff),
   .single_rd    (single_rd),
   .single_valid (single_valid),
   .single_ovf   (single_ovf),
   .scan_rd      (scan_rd),
   .scan_valid   (scan_valid),
   .scan_ovf     (scan_ovf)
);

// File: tb/test_adc_conv_sched.sv
module test_adc_conv_sched;
   localparam int N   = 8;
   localparam int CW  = 3;
   localparam int RW  = 12;
   localparam int LAT = 3;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic rst_n = 1'b0;
   logic tailgate_en = 0, single_trig = 0, single_diff = 0, single_repeat = 0, single_rd = 0;
   logic [CW-1:0] single_chan = '0;
   logic scan_trig = 0, scan_diff = 0, scan_repeat = 0, scan_rd = 0;
   logic [N-1:0] scan_mask = '0;
   logic core_done = 1'b0;
   logic [RW-1:0] core_result = '0;
   logic [RW-1:0] single_data, scan_data;
   logic [CW-1:0] scan_chan, core_chan;
   logic single_valid, single_ovf, scan_valid, scan_ovf, core_start, core_diff;

   adc_conv_sched #(.N_INPUTS(N), .RES_W(RW)) i_adc_conv_sched (
      .clk(clk), .rst_n(rst_n), .tailgate_en(tailgate_en),
      .single_trig(single_trig), .single_chan(single_chan), .single_diff(single_diff),
      .single_repeat(single_repeat), .single_rd(single_rd), .single_data(single_data),
      .single_valid(single_valid), .single_ovf(single_ovf),
      .scan_trig(scan_trig), .scan_mask(scan_mask), .scan_diff(scan_diff),
      .scan_repeat(scan_repeat), .scan_rd(scan_rd), .scan_data(scan_data),
      .scan_chan(scan_chan), .scan_valid(scan_valid), .scan_ovf(scan_ovf),
      .core_start(core_start), .core_chan(core_chan), .core_diff(core_diff),
      .core_done(core_done), .core_result(core_result));

   int n_cmp = 0, n_bad = 0;

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // Core model: done pulse LAT falling edges after a start is seen
   int cd = 0, nres = 0;
   always @(negedge clk) begin
      core_done = 1'b0;
      if (cd > 0) begin
         cd--;
         if (cd == 0) begin
            core_done   = 1'b1;
            nres++;
            core_result = RW'(nres * 53 + 17);
         end
      end
      if (rst_n && core_start) cd = LAT;
   end

   // Behavioural reference model, advanced on each rising edge
   bit m_busy, m_scan_owner, m_sreq, m_srel, m_sact, m_begun;
   int m_q[$];
   bit m_start, m_diff;
   int m_chan, m_cch;
   logic [RW-1:0] m_sd, m_cd;
   bit m_sv, m_cv, m_so, m_co;

   always @(posedge clk) begin : model
      bit done, sc_el, sg_el, tk_s, tk_c, sw_end, s_fin;
      if (!rst_n) begin
         m_busy = 0; m_scan_owner = 0; m_sreq = 0; m_srel = 0; m_sact = 0; m_begun = 0;
         m_q.delete(); m_start = 0; m_diff = 0; m_chan = 0; m_cch = 0;
         m_sd = '0; m_cd = '0; m_sv = 0; m_cv = 0; m_so = 0; m_co = 0;
      end else begin
         done   = m_busy && core_done;
         sc_el  = m_sact && m_q.size() != 0;
         sg_el  = m_sreq && (!tailgate_en || m_srel);
         tk_s   = !m_busy && sg_el && (!sc_el || m_begun || tailgate_en);
         tk_c   = !m_busy && sc_el && !tk_s;
         sw_end = done && m_scan_owner && m_q.size() == 0;
         s_fin  = done && !m_scan_owner;
         if (s_fin) begin
            if (m_sv && !single_rd) m_so = 1;
            m_sd = core_result; m_sv = 1;
         end else if (single_rd) m_sv = 0;
         if (done && m_scan_owner) begin
            if (m_cv && !scan_rd) m_co = 1;
            m_cd = core_result; m_cch = m_chan; m_cv = 1;
         end else if (scan_rd) m_cv = 0;
         if (m_sreq) begin
            if (s_fin && !single_repeat) m_sreq = 0;
         end else if (single_trig) m_sreq = 1;
         if (tk_s) m_srel = 0;
         else if (sw_end && m_sreq) m_srel = 1;
         m_start = tk_s || tk_c;
         if (tk_s) begin m_chan = int'(single_chan); m_diff = single_diff; m_scan_owner = 0; end
         if (tk_c) begin m_chan = m_q.pop_front(); m_diff = scan_diff; m_scan_owner = 1; m_begun = 1; end
         if (tk_s || tk_c) m_busy = 1;
         else if (done) m_busy = 0;
         if (sw_end) begin
            if (scan_repeat && scan_mask != 0) begin
               m_q.delete();
               for (int i = 0; i < N; i++) if (scan_mask[i]) m_q.push_back(i);
               m_begun = 0;
            end else m_sact = 0;
         end else if (!m_sact && scan_trig && scan_mask != 0) begin
            m_sact = 1; m_begun = 0; m_q.delete();
            for (int i = 0; i < N; i++) if (scan_mask[i]) m_q.push_back(i);
         end
      end
   end

   // Per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 core_start", 32'(core_start), 32'(m_start));
         chk("R5 core_chan", 32'(core_chan), 32'(m_chan));
         chk("R9 core_diff", 32'(core_diff), 32'(m_diff));
         chk("R7 single_valid", 32'(single_valid), 32'(m_sv));
         chk("R8 single_data", 32'(single_data), 32'(m_sd));
         chk("R11 single_ovf", 32'(single_ovf), 32'(m_so));
         chk("R7 scan_valid", 32'(scan_valid), 32'(m_cv));
         chk("R8 scan_data", 32'(scan_data), 32'(m_cd));
         chk("R5 scan_chan", 32'(scan_chan), 32'(m_cch));
         chk("R11 scan_ovf", 32'(scan_ovf), 32'(m_co));
      end
   end

   // Issue log: channel nibbles in order, count and any differential start
   int log_seq = 0, log_n = 0;
   bit log_diff = 0;
   always @(negedge clk) begin
      if (rst_n && core_start) begin
         log_seq = (log_seq << 4) | int'(core_chan);
         log_n++;
         log_diff |= core_diff;
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic clr_log();
      log_seq = 0; log_n = 0; log_diff = 0;
   endtask
   task automatic trig_single();
      single_trig = 1; tick(1); single_trig = 0;
   endtask
   task automatic trig_scan();
      scan_trig = 1; tick(1); scan_trig = 0;
   endtask
   task automatic read_both();
      single_rd = 1; scan_rd = 1; tick(1); single_rd = 0; scan_rd = 0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R3 watchdog: actual 20000 cycles expected completion earlier");
      summary();
      $finish;
   end

   int hold_n;
   initial begin
      tick(3);
      // R1: reset state
      chk("R1 reset single_valid", 32'(single_valid), 0);
      chk("R1 reset scan_valid", 32'(scan_valid), 0);
      chk("R1 reset core_start", 32'(core_start), 0);
      chk("R1 reset ovf", 32'({single_ovf, scan_ovf}), 0);
      rst_n = 1'b1;
      tick(2);

      // R1/R9: single once, channel 5, differential
      clr_log(); single_chan = 3'd5; single_diff = 1; trig_single(); tick(15);
      chk("R1 single conversions", 32'(log_n), 1);
      chk("R9 diff forwarded", 32'(log_diff), 1);
      chk("R7 single valid set", 32'(single_valid), 1);
      tick(5);
      chk("R8 peek keeps valid", 32'(single_valid), 1);
      read_both();
      chk("R7 read clears valid", 32'(single_valid), 0);

      // R5/R11: scan mask {1,2,3}, no reads -> overflow on scan only
      clr_log(); single_diff = 0; single_chan = 3'd7; scan_mask = 8'h0E; trig_scan(); tick(30);
      chk("R5 ascending sweep", 32'(log_seq), 32'h123);
      chk("R5 last scan channel", 32'(scan_chan), 3);
      chk("R11 scan overflow", 32'(scan_ovf), 1);
      chk("R11 single no overflow", 32'(single_ovf), 0);
      read_both();

      // R5: empty mask
      clr_log(); scan_mask = 8'h00; trig_scan(); tick(15);
      chk("R5 empty mask no start", 32'(log_n), 0);
      chk("R5 empty mask no valid", 32'(scan_valid), 0);
      scan_mask = 8'h0E;

      // R2/R4: both triggered together
      clr_log(); single_trig = 1; scan_trig = 1; tick(1); single_trig = 0; scan_trig = 0; tick(35);
      chk("R2 scan first then single slotted", 32'(log_seq), 32'h1723);
      chk("R11 single no overflow yet", 32'(single_ovf), 0);

      // R3: single running, scan trigger waits for it
      clr_log(); trig_single(); trig_scan(); tick(35);
      chk("R3 single not preempted", 32'(log_seq), 32'h7123);
      chk("R11 single overflow", 32'(single_ovf), 1);

      // R4/R10: single mid-sweep; extra triggers merged
      clr_log(); trig_scan(); tick(2); trig_single(); trig_single(); trig_scan(); tick(40);
      chk("R4 single between scan samples", 32'(log_seq), 32'h1723);
      chk("R10 merged triggers", 32'(log_n), 4);

      // R6: tailgate, single during sweep waits for its end
      tailgate_en = 1;
      clr_log(); trig_scan(); tick(2); trig_single(); tick(40);
      chk("R6 single after sweep", 32'(log_seq), 32'h1237);

      // R6: tailgate, single waits for a sweep that starts later
      clr_log(); trig_single(); tick(30);
      chk("R6 single held without sweep", 32'(log_n), 0);
      trig_scan(); tick(40);
      chk("R6 held single after next sweep", 32'(log_seq), 32'h1237);
      tailgate_en = 0;
      read_both();

      // R12: repeating single, then stop
      clr_log(); single_repeat = 1; trig_single(); tick(30);
      chk("R12 single repeats", 32'(log_n >= 4), 1);
      single_repeat = 0; tick(15);
      hold_n = log_n; tick(20);
      chk("R12 single stops", 32'(log_n), 32'(hold_n));

      // R12: repeating scan over {1,2}, then stop
      clr_log(); scan_mask = 8'h06; scan_repeat = 1; trig_scan(); tick(40);
      chk("R12 scan repeats", 32'(log_n >= 5), 1);
      scan_repeat = 0; tick(20);
      hold_n = log_n; tick(20);
      chk("R12 scan stops", 32'(log_n), 32'(hold_n));
      chk("R12 sweep ends on last input", 32'(scan_chan), 2);

      tick(5);
      summary();
      $finish;
   end

endmodule